// File: doc/BRIEF.md
# Sign-Magnitude Non-Restoring Divider

This block divides one unsigned magnitude by another using the non-restoring method and returns results in sign-magnitude form. The caller presents a dividend and a divisor, each given as a sign bit and a W-bit magnitude. While the block is idle, the caller pulses `start` for one clock to hand them over. The magnitudes go through W shift-and-add/subtract iterations. A working remainder that goes negative is never restored: the next step adds the divisor instead of subtracting it. If the remainder is still negative after the last iteration, one extra cycle adds the divisor back. The two signs never enter the arithmetic and are resolved separately.

The controller is a four-state machine:
- `ST_IDLE` waits for `start`.
- `ST_STEP` runs the W iterations.
- `ST_FIX` performs the optional remainder correction.
- `ST_DONE` presents a one-cycle `done` pulse.

The transitions are:
- IDLE→STEP when `start` arrives with a nonzero divisor.
- IDLE→DONE when `start` arrives with a zero divisor.
- STEP→STEP while iterations remain.
- STEP→FIX when the last iteration leaves a negative remainder.
- STEP→DONE when the last iteration leaves a non-negative remainder.
- FIX→DONE and DONE→IDLE unconditionally.

The results stay on the outputs from `done` until the next accepted start.

Top module: `sm_nr_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0.
- R2: For a nonzero divisor magnitude B and dividend magnitude A, `quo_mag` equals floor(A/B) and `rem_mag` equals A mod B when `done` is 1.
- R3: When `done` is 1, `quo_sign` equals the XOR of the dividend sign and the divisor sign captured at the accepted start.
- R4: When `done` is 1, `rem_sign` equals the captured dividend sign.
- R5: Latency is counted in rising edges, including the edge that samples `start`. For a nonzero divisor, `done` is high after W+1 edges when bit 0 of the quotient is 1, and after W+2 edges when it is 0, because a negative final remainder costs one correction cycle.
- R6: `done` is high for exactly one cycle. The result outputs then hold their values until the next accepted start.
- R7: `busy` is 1 from the edge after an accepted start through the cycle in which `done` is high, and 0 otherwise.
- R8: A `start` pulse while `busy` is 1 is ignored. The operands and results of the running division are unaffected.
- R9: A zero divisor magnitude skips iteration. `done` and `div_zero` rise after one edge, `quo_mag` is 0 and `rem_mag` equals the dividend magnitude. `div_zero` clears on the next accepted start with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only when idle |
| dvd_sign | input | 1 | Dividend sign (1 = negative) |
| dvd_mag | input | W | Dividend magnitude |
| dvs_sign | input | 1 | Divisor sign (1 = negative) |
| dvs_mag | input | W | Divisor magnitude |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last division had a zero divisor |
| quo_sign | output | 1 | Quotient sign |
| quo_mag | output | W | Quotient magnitude |
| rem_sign | output | 1 | Remainder sign |
| rem_mag | output | W | Remainder magnitude |

## Verification
The correction cycle is the hardest path to reach deliberately. It occurs only when the final working remainder is negative, which happens exactly when the quotient is even. The bench therefore pairs operands with odd and even quotients, including a zero dividend and a dividend smaller than the divisor, and checks the one-cycle latency difference against the quotient parity. A start pulse raised mid-iteration with different operands exercises the rule that requests arriving while busy are dropped.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } div_state_t;
endpackage

// File: rtl/sm_div_step.sv
// One non-restoring iteration: shift remainder/quotient left, then add or
// subtract the divisor depending on the sign of the incoming remainder.
module sm_div_step #(
    parameter int W = 8
) (
    input  logic [W+1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W+1:0] rem_o,
    output logic [W-1:0] quo_o,
    output logic         neg_o
);
    localparam int RW = W + 2;

    logic [RW-1:0] shifted;
    logic [RW-1:0] dvs_ext;

    always_comb begin
        shifted = {rem_i[RW-2:0], quo_i[W-1]};
        dvs_ext = {2'b00, dvs_i};
        if (rem_i[RW-1]) begin
            rem_o = shifted + dvs_ext;
        end else begin
            rem_o = shifted - dvs_ext;
        end
        neg_o = rem_o[RW-1];
        quo_o = {quo_i[W-2:0], ~rem_o[RW-1]};
    end
endmodule

// File: rtl/sm_div_fix.sv
// Final correction: add the divisor back once to a negative remainder.
module sm_div_fix #(
    parameter int W = 8
) (
    input  logic [W+1:0] rem_i,
    input  logic [W-1:0] dvs_i,
    output logic [W+1:0] rem_o
);
    always_comb begin
        rem_o = rem_i + {2'b00, dvs_i};
    end
endmodule

// File: rtl/sm_div_sign.sv
// Sign resolution, kept apart from the magnitude arithmetic.
module sm_div_sign (
    input  logic dvd_s,
    input  logic dvs_s,
    output logic quo_s,
    output logic rem_s
);
    always_comb begin
        quo_s = dvd_s ^ dvs_s;
        rem_s = dvd_s;
    end
endmodule

// File: rtl/sm_div_ctrl.sv
module sm_div_ctrl
    import sm_div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dvs_zero,
    input  logic step_neg,
    output logic load,
    output logic step_en,
    output logic fix_en,
    output logic busy,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;

    // State register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STEP) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = dvs_zero ? ST_DONE : ST_STEP;
                end
            end
            ST_STEP: begin
                if (cnt_q == LAST) begin
                    state_d = step_neg ? ST_FIX : ST_DONE;
                end
            end
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        fix_en  = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_STEP: step_en = 1'b1;
            ST_FIX:  fix_en  = 1'b1;
            ST_DONE: done    = 1'b1;
            default: busy    = 1'b0;
        endcase
    end
endmodule

// File: rtl/sm_nr_divider.sv
module sm_nr_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         dvd_sign,
    input  logic [W-1:0] dvd_mag,
    input  logic         dvs_sign,
    input  logic [W-1:0] dvs_mag,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic         quo_sign,
    output logic [W-1:0] quo_mag,
    output logic         rem_sign,
    output logic [W-1:0] rem_mag
);
    localparam int RW = W + 2;

    logic          load, step_en, fix_en, step_neg, dvs_zero;
    logic [RW-1:0] rem_q, rem_nx, rem_fx;
    logic [W-1:0]  quo_q, quo_nx;
    logic [W-1:0]  dvs_mag_q;
    logic          dvd_s_q, dvs_s_q, zero_q;

    assign dvs_zero = (dvs_mag == '0);

    sm_div_ctrl #(.W(W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dvs_zero (dvs_zero),
        .step_neg (step_neg),
        .load     (load),
        .step_en  (step_en),
        .fix_en   (fix_en),
        .busy     (busy),
        .done     (done)
    );

    sm_div_step #(.W(W)) step_i (
        .rem_i (rem_q),
        .quo_i (quo_q),
        .dvs_i (dvs_mag_q),
        .rem_o (rem_nx),
        .quo_o (quo_nx),
        .neg_o (step_neg)
    );

    sm_div_fix #(.W(W)) fix_i (
        .rem_i (rem_q),
        .dvs_i (dvs_mag_q),
        .rem_o (rem_fx)
    );

    sm_div_sign sign_i (
        .dvd_s (dvd_s_q),
        .dvs_s (dvs_s_q),
        .quo_s (quo_sign),
        .rem_s (rem_sign)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            quo_q     <= '0;
            dvs_mag_q <= '0;
            dvd_s_q   <= 1'b0;
            dvs_s_q   <= 1'b0;
            zero_q    <= 1'b0;
        end else if (load) begin
            dvs_mag_q <= dvs_mag;
            dvd_s_q   <= dvd_sign;
            dvs_s_q   <= dvs_sign;
            zero_q    <= dvs_zero;
            if (dvs_zero) begin
                rem_q <= {2'b00, dvd_mag};
                quo_q <= '0;
            end else begin
                rem_q <= '0;
                quo_q <= dvd_mag;
            end
        end else if (step_en) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
        end else if (fix_en) begin
            rem_q <= rem_fx;
        end
    end

    assign div_zero = zero_q;
    assign quo_mag  = quo_q;
    assign rem_mag  = rem_q[W-1:0];
endmodule

// File: rtl/sm_nr_divider_chk.sv
module sm_nr_divider_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dvd_mag,
    input logic [W-1:0] dvs_mag,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic [W-1:0] quo_mag,
    input logic [W-1:0] rem_mag,
    input logic [W-1:0] dvs_mag_q
);
    localparam int PW = 2 * W;

    logic [W-1:0] a_cap, b_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cap <= '0;
            b_cap <= '0;
        end else if (start && !busy) begin
            a_cap <= dvd_mag;
            b_cap <= dvs_mag;
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dvs_mag_q));

    assert_rem_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (rem_mag < b_cap));

    assert_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |->
        (PW'(quo_mag) * PW'(b_cap) + PW'(rem_mag) == PW'(a_cap)));

    assert_zero_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quo_mag == '0 && rem_mag == a_cap));
endmodule

bind sm_nr_divider sm_nr_divider_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dvd_mag   (dvd_mag),
    .dvs_mag   (dvs_mag),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero),
    .quo_mag   (quo_mag),
    .rem_mag   (rem_mag),
    .dvs_mag_q (dvs_mag_q)
);

// File: tb/sm_nr_divider_tb.sv
module sm_nr_divider_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dvd_sign = 1'b0;
    logic [W-1:0] dvd_mag = '0;
    logic         dvs_sign = 1'b0;
    logic [W-1:0] dvs_mag = '0;
    logic         busy, done, div_zero, quo_sign, rem_sign;
    logic [W-1:0] quo_mag, rem_mag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sm_nr_divider #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_sign(dvd_sign), .dvd_mag(dvd_mag),
        .dvs_sign(dvs_sign), .dvs_mag(dvs_mag),
        .busy(busy), .done(done), .div_zero(div_zero),
        .quo_sign(quo_sign), .quo_mag(quo_mag),
        .rem_sign(rem_sign), .rem_mag(rem_mag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Launch an operation; optionally pulse a second start while busy.
    task automatic run_div(input int a, input bit as, input int b, input bit bs,
                           input bit intrude);
        int cyc;
        int q, r, lat;
        if (b == 0) begin
            q = 0; r = a; lat = 1;
        end else begin
            q = a / b; r = a % b;
            lat = (q % 2 == 1) ? W + 1 : W + 2;
        end
        @(negedge clk);
        dvd_mag = W'(a); dvd_sign = as; dvs_mag = W'(b); dvs_sign = bs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        if (intrude && !done) begin
            @(negedge clk); cyc++;
            dvd_mag = W'(a ^ 8'h5A); dvs_mag = W'(3); dvd_sign = ~as; dvs_sign = ~bs;
            start = 1'b1;
            @(negedge clk); cyc++;
            start = 1'b0;
        end
        while (!done && cyc < 40) begin
            @(negedge clk); cyc++;
        end
        chk(cyc == lat, (b == 0) ? "R9 latency" : "R5 latency", cyc, lat);
        chk(int'(quo_mag) == q, intrude ? "R8 quotient" : "R2 quotient", int'(quo_mag), q);
        chk(int'(rem_mag) == r, intrude ? "R8 remainder" : "R2 remainder", int'(rem_mag), r);
        chk(quo_sign == (as ^ bs), "R3 quotient sign", int'(quo_sign), int'(as ^ bs));
        chk(rem_sign == as, "R4 remainder sign", int'(rem_sign), int'(as));
        chk(div_zero == (b == 0), "R9 div_zero flag", int'(div_zero), int'(b == 0));
        chk(busy == 1'b1, "R7 busy during done", int'(busy), 1);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
        chk(busy == 1'b0, "R7 busy clear after done", int'(busy), 0);
        dvd_mag = '1; dvs_mag = 8'd7;
        repeat (3) @(negedge clk);
        chk(int'(quo_mag) == q && int'(rem_mag) == r, "R6 results held",
            int'(quo_mag), q);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 0 && done == 0 && div_zero == 0, "R1 reset state",
            int'({busy, done, div_zero}), 0);
    endtask

    task automatic t_basic();
        run_div(7, 0, 2, 0, 0);      // odd quotient, no correction
        run_div(100, 1, 7, 0, 0);    // even quotient, correction
        run_div(200, 0, 13, 1, 0);
        run_div(255, 1, 1, 1, 0);    // divide by one
    endtask

    task automatic t_boundaries();
        run_div(0, 0, 5, 0, 0);      // zero dividend
        run_div(3, 1, 250, 0, 0);    // dividend below divisor
        run_div(255, 0, 255, 0, 0);  // equal maximum operands
        run_div(128, 1, 2, 1, 0);    // exact division
    endtask

    task automatic t_zero_div();
        run_div(77, 1, 0, 0, 0);
        run_div(9, 0, 4, 0, 0);      // flag clears on next nonzero divisor (R9)
    endtask

    task automatic t_ignore();
        run_div(201, 0, 10, 1, 1);   // start while busy is dropped (R8)
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_boundaries();
        t_zero_div();
        t_ignore();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule